// File: doc/BRIEF.md
# Indirect Command/Status Bus Bridge

The bridge gives a host a window of 64-bit registers through which it can issue single transactions onto an internal bus with 32-bit addresses. Software first loads a 32-bit write value into the data register when it needs one. It then writes a command word that names the direction, the byte count and the target address. That one write both describes the operation and starts it. The bridge places one request on its master port and waits for the response. It then packs the outcome into a status word.

The status word carries a completion flag. For reads it also carries the returned bytes, or all-ones when the bus reported an error. Reading the status word hands its value to the host and wipes it, so a poll loop sees each result only once. Only one transaction can be outstanding at a time, and a command written while the bridge waits for a response is dropped.

Top module: `ind_cmd_bridge`

## Requirements
- R1: The register is chosen by host_addr[4:3]. 0 is command, 2 is status, 3 is data and 1 is unused. Reading index 0 or index 1 returns zero.
- R2: Fields of the command word use LSB-0 bit numbers. Bit 48 set means a read and bit 48 clear means a write. Bits 59:56 give the byte count and bits 31:0 give the bus address. On the clock edge after an accepted command write, bus_req is high for exactly one cycle, with bus_we equal to the inverse of bit 48 and with bus_size and bus_addr taken from the word. The other command bits have no effect.
- R3: A write to the data register keeps host_wdata[63:32]. A read of the data register returns that value in bits 63:32 and zeros in bits 31:0. A write command drives the stored value on bus_wdata, with the byte at the lowest address in bits 31:24.
- R4: A successful read response sets status to bit 11 (done) together with the 32 read bits placed at status bits 57:26.
- R5: A read response with bus_rsp_err high sets status to bit 11 together with all-ones in bits 57:26.
- R6: A write response sets status to bit 11 alone, whatever the value of bus_rsp_err.
- R7: A status read returns the current value, and the status then reads zero until the next response.
- R8: While a response is outstanding, a command write is ignored: no new bus_req is issued and the bus fields hold. A response arriving while the bridge is idle is ignored.
- R9: Writes to index 1 and index 2 change neither the status, the data register nor the bus port.
- R10: After reset the status and data registers read zero and bus_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | HOST_AW | Host byte address; bits 4:3 select the register |
| host_wdata | input | HW | Host write word |
| host_rdata | output | HW | Read word of the selected register, valid in the cycle of host_req |
| bus_req | output | 1 | One-cycle request toward the internal bus |
| bus_we | output | 1 | 1 for a write transaction |
| bus_addr | output | BUS_AW | Transaction address |
| bus_size | output | SIZE_W | Transaction byte count |
| bus_wdata | output | BUS_DW | Write data, big-endian byte order |
| bus_rsp_valid | input | 1 | Response strobe from the internal bus |
| bus_rsp_err | input | 1 | Response carries an error |
| bus_rsp_rdata | input | BUS_DW | Read data of the response |

## Verification
A busy flag stuck high shows up at the port as a missing bus_req on the very next command, one edge after the write. A busy flag stuck low shows up as a spurious request, or as an idle response landing in status. Status corruption surfaces at the first status read after a response, either as a wrong packed field or as a value that does not read zero on the second read. A wrongly captured data or command field is visible on the bus port one cycle after the command write. The sweep varies direction, error, byte count, address and data together, so a bit dropped or misplaced in any field changes at least one observed word.

// File: rtl/icb_pkg.sv
package icb_pkg;
  // register index taken from host_addr[IDX_LSB+1:IDX_LSB]
  localparam int IDX_LSB    = 3;
  // command and status field positions, LSB-0 numbering of the 64-bit word
  localparam int CMD_RD_BIT = 48;
  localparam int CMD_SZ_LO  = 56;
  localparam int DONE_BIT   = 11;
  localparam int RD_LSH     = 26;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_RSV  = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/icb_hostif.sv
module icb_hostif
  import icb_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int HW      = 64,
  parameter int BUS_DW  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HW-1:0]      host_wdata,
  input  logic [HW-1:0]      stat_q,
  output logic [HW-1:0]      host_rdata,
  output logic               wr_cmd,
  output logic               rd_stat,
  output logic [BUS_DW-1:0]  data_q
);
  localparam int PAD_W = HW - BUS_DW;

  reg_idx_e          idx;
  logic              wr_data;
  logic [BUS_DW-1:0] data_d;
  logic              unused_host;

  assign unused_host = ^{host_addr, host_wdata};

  always_comb begin
    idx     = reg_idx_e'(host_addr[IDX_LSB +: 2]);
    wr_cmd  = host_req &  host_we & (idx == REG_CMD);
    wr_data = host_req &  host_we & (idx == REG_DATA);
    rd_stat = host_req & ~host_we & (idx == REG_STAT);
    data_d  = host_wdata[HW-1 -: BUS_DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_data) begin
      data_q <= data_d;
    end
  end

  always_comb begin
    unique case (idx)
      REG_STAT: host_rdata = stat_q;
      REG_DATA: host_rdata = {data_q, {PAD_W{1'b0}}};
      default:  host_rdata = '0;
    endcase
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(data_q)) else $error("data register changed without a write"); // R3
endmodule

// File: rtl/icb_xact.sv
module icb_xact
  import icb_pkg::*;
#(
  parameter int HW     = 64,
  parameter int BUS_AW = 32,
  parameter int BUS_DW = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [HW-1:0]     cmd_word,
  input  logic [BUS_DW-1:0] data_q,
  input  logic              rsp_valid,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [SIZE_W-1:0] bus_size,
  output logic [BUS_DW-1:0] bus_wdata,
  output logic              rsp_fire,
  output logic              op_read
);
  logic busy_q, busy_d;
  logic req_q, req_d;
  logic accept;
  logic rd_q;
  logic [BUS_AW-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [BUS_DW-1:0] wd_q;
  logic              unused_cmd;

  assign unused_cmd = ^cmd_word;

  always_comb begin
    accept   = cmd_wr & ~busy_q;
    rsp_fire = busy_q & rsp_valid;
    req_d    = accept;
    busy_d   = busy_q;
    if (accept) begin
      busy_d = 1'b1;
    end else if (rsp_fire) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
      size_q <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      rd_q   <= cmd_word[CMD_RD_BIT];
      addr_q <= cmd_word[BUS_AW-1:0];
      size_q <= cmd_word[CMD_SZ_LO +: SIZE_W];
      wd_q   <= data_q;
    end
  end

  assign bus_req   = req_q;
  assign bus_we    = ~rd_q;
  assign bus_addr  = addr_q;
  assign bus_size  = size_q;
  assign bus_wdata = wd_q;
  assign op_read   = rd_q;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req) else $error("bus_req longer than one cycle"); // R2
  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy_q |=> !bus_req) else $error("command accepted while busy"); // R8
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !rsp_valid |=> $stable(addr_q) && $stable(rd_q) && $stable(size_q))
    else $error("bus fields moved while busy"); // R8
endmodule

// File: rtl/icb_status.sv
module icb_status
  import icb_pkg::*;
#(
  parameter int HW     = 64,
  parameter int BUS_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_fire,
  input  logic              op_read,
  input  logic              rsp_err,
  input  logic [BUS_DW-1:0] rsp_rdata,
  input  logic              clr,
  output logic [HW-1:0]     stat_q
);
  logic [HW-1:0]     stat_d;
  logic [HW-1:0]     done_m;
  logic [BUS_DW-1:0] rd32;
  logic              stat_en;

  always_comb begin
    done_m           = '0;
    done_m[DONE_BIT] = 1'b1;
    rd32             = rsp_err ? {BUS_DW{1'b1}} : rsp_rdata;
    stat_en          = rsp_fire | clr;
    stat_d           = '0;
    if (rsp_fire) begin
      stat_d = done_m;
      if (op_read) begin
        stat_d[RD_LSH +: BUS_DW] = rd32;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !rsp_fire |=> stat_q == '0) else $error("status not cleared"); // R7
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> stat_q[DONE_BIT]) else $error("done flag missing"); // R4
  AST_WR_DONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && !op_read |=> $countones(stat_q) == 1 && stat_q[DONE_BIT])
    else $error("write status carries extra bits"); // R6
  AST_FAIL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && op_read && rsp_err |=> &stat_q[RD_LSH +: BUS_DW])
    else $error("failed read not all-ones"); // R5
endmodule

// File: rtl/ind_cmd_bridge.sv
module ind_cmd_bridge #(
  parameter int HOST_AW = 8,
  parameter int HW      = 64,
  parameter int BUS_AW  = 32,
  parameter int BUS_DW  = 32,
  parameter int SIZE_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HW-1:0]      host_wdata,
  output logic [HW-1:0]      host_rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic [BUS_AW-1:0]  bus_addr,
  output logic [SIZE_W-1:0]  bus_size,
  output logic [BUS_DW-1:0]  bus_wdata,
  input  logic               bus_rsp_valid,
  input  logic               bus_rsp_err,
  input  logic [BUS_DW-1:0]  bus_rsp_rdata
);
  logic rst_meta, rst_sync;
  logic wr_cmd, rd_stat, rsp_fire, op_read;
  logic [BUS_DW-1:0] data_q;
  logic [HW-1:0]     stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  icb_hostif #(.HOST_AW(HOST_AW), .HW(HW), .BUS_DW(BUS_DW)) u_hostif (
    .clk        (clk),
    .rst_n      (rst_sync),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .stat_q     (stat_q),
    .host_rdata (host_rdata),
    .wr_cmd     (wr_cmd),
    .rd_stat    (rd_stat),
    .data_q     (data_q)
  );

  icb_xact #(.HW(HW), .BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .SIZE_W(SIZE_W)) u_xact (
    .clk       (clk),
    .rst_n     (rst_sync),
    .cmd_wr    (wr_cmd),
    .cmd_word  (host_wdata),
    .data_q    (data_q),
    .rsp_valid (bus_rsp_valid),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .rsp_fire  (rsp_fire),
    .op_read   (op_read)
  );

  icb_status #(.HW(HW), .BUS_DW(BUS_DW)) u_status (
    .clk       (clk),
    .rst_n     (rst_sync),
    .rsp_fire  (rsp_fire),
    .op_read   (op_read),
    .rsp_err   (bus_rsp_err),
    .rsp_rdata (bus_rsp_rdata),
    .clr       (rd_stat),
    .stat_q    (stat_q)
  );
endmodule

// File: tb/sim_ind_cmd_bridge.sv
module sim_ind_cmd_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [7:0]  host_addr;
  logic [63:0] host_wdata, host_rdata;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_size;
  logic        bus_rsp_valid, bus_rsp_err;
  logic [31:0] bus_rsp_rdata;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ind_cmd_bridge u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
    .bus_rsp_rdata(bus_rsp_rdata)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [63:0] v);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 8'(idx << 3) | 8'h40; host_wdata = v;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [63:0] v);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 8'(idx << 3) | 8'h80;
    #1 v = host_rdata;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic respond(input logic err, input logic [31:0] d);
    bus_rsp_valid = 1'b1; bus_rsp_err = err; bus_rsp_rdata = d;
    @(negedge clk);
    bus_rsp_valid = 1'b0; bus_rsp_err = 1'b0; bus_rsp_rdata = '0;
  endtask

  function automatic logic [63:0] mk_cmd(input logic rdop, input logic [3:0] sz, input logic [31:0] a);
    logic [63:0] c;
    c = 64'h4000_0100_0000_0000;   // bits 62 and 40: no effect
    c[48] = rdop;
    c[59:56] = sz;
    c[31:0] = a;
    return c;
  endfunction

  function automatic logic [63:0] exp_stat(input logic rdop, input logic err, input logic [31:0] d);
    logic [63:0] s;
    s = 64'h800;
    if (rdop) s = s | (64'(err ? 32'hFFFF_FFFF : d) << 26);
    return s;
  endfunction

  initial begin
    logic [63:0] v;
    logic [31:0] cur_data;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    bus_rsp_valid = 1'b0; bus_rsp_err = 1'b0; bus_rsp_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state, R1 unused index reads
    for (int i = 0; i < 4; i++) begin
      rd(i, v);
      chk(v, 64'h0, "R10 reset read");
    end
    chk(64'(bus_req), 64'h0, "R10 bus_req idle");

    // R3 data register, R1 zero reads
    wr(3, 64'hA1B2C3D4_55667788);
    rd(3, v); chk(v, 64'hA1B2C3D4_00000000, "R3 data readback");
    rd(0, v); chk(v, 64'h0, "R1 command reads zero");
    rd(1, v); chk(v, 64'h0, "R1 index1 reads zero");
    cur_data = 32'hA1B2C3D4;

    // sweep: direction, error, size, address, data
    for (int i = 0; i < 32; i++) begin
      logic        rdop, err;
      logic [3:0]  sz;
      logic [31:0] a, dv, rv;
      rdop = i[0]; err = i[1]; sz = 4'(i * 5 + 1);
      a  = 32'h1000_0000 + 32'(i) * 32'h0101_0013;
      dv = 32'hC0DE_0000 ^ (32'(i) * 32'h0031_7F05);
      rv = 32'h8000_0001 ^ (32'(i) * 32'h0412_3457);
      wr(3, {dv, 32'hFFFF_FFFF});
      cur_data = dv;
      wr(0, mk_cmd(rdop, sz, a));
      chk(64'(bus_req), 64'h1, "R2 bus_req after command");
      chk(64'(bus_we), 64'(!rdop), "R2 bus_we");
      chk(64'(bus_addr), 64'(a), "R2 bus_addr");
      chk(64'(bus_size), 64'(sz), "R2 bus_size");
      if (!rdop) chk(64'(bus_wdata), 64'(dv), "R3 bus_wdata");
      @(negedge clk);
      chk(64'(bus_req), 64'h0, "R2 single-cycle request");
      respond(err, rv);
      rd(2, v);
      chk(v, exp_stat(rdop, err, rv), rdop ? (err ? "R5 failed read status" : "R4 read status")
                                           : "R6 write status");
      rd(2, v);
      chk(v, 64'h0, "R7 status cleared");
    end

    // R8 command while outstanding
    wr(0, mk_cmd(1'b1, 4'd4, 32'hAAAA_0000));
    chk(64'(bus_req), 64'h1, "R8 first command issued");
    @(negedge clk);
    wr(0, mk_cmd(1'b0, 4'd2, 32'h5555_0000));
    chk(64'(bus_req), 64'h0, "R8 busy command no request");
    chk(64'(bus_addr), 64'hAAAA_0000, "R8 bus_addr held");
    @(negedge clk);
    chk(64'(bus_req), 64'h0, "R8 still no request");
    respond(1'b0, 32'h1234_5678);
    rd(2, v);
    chk(v, exp_stat(1'b1, 1'b0, 32'h1234_5678), "R8 status of first command");
    wr(0, mk_cmd(1'b0, 4'd1, 32'h0000_0077));
    chk(64'(bus_req), 64'h1, "R8 accepted again after response");
    respond(1'b1, 32'h0);
    rd(2, v);
    chk(v, 64'h800, "R6 failed write done only");

    // R8 idle response ignored
    @(negedge clk);
    respond(1'b0, 32'hDEAD_BEEF);
    rd(2, v);
    chk(v, 64'h0, "R8 idle response ignored");

    // R9 writes to index 1 and 2 ignored
    wr(0, mk_cmd(1'b1, 4'd4, 32'h0000_0100));
    respond(1'b0, 32'h0F0F_0F0F);
    wr(2, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(64'(bus_req), 64'h0, "R9 index2 write no request");
    wr(1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(64'(bus_req), 64'h0, "R9 index1 write no request");
    rd(3, v);
    chk(v, {cur_data, 32'h0}, "R9 data unchanged");
    rd(2, v);
    chk(v, exp_stat(1'b1, 1'b0, 32'h0F0F_0F0F), "R9 status unchanged");

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog R2 actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule